// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block is the host-facing register set of one channel of a bus-master storage DMA engine. It holds a command register with a run bit and a transfer-direction bit, a status register with active, error and interrupt flags, and a descriptor-table base pointer. It also holds the working pointer that a separate descriptor walker advances while it fetches table entries. Register writes are decoded into start and stop events for that walker. The device interrupt is forwarded to the host, and its rising edge is recorded in the status register.

Software loads the table base through byte-lane writes, sets the run bit, and waits for the host interrupt. It then clears the run bit and acknowledges the interrupt by writing ones to the status flags. The walker reports completion, errors and pointer steps back through dedicated inputs. A stop request clears the active flag only; the walker is left to finish a transfer that is already in flight.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, cmd_rdata, sts_rdata, tbl_base, work_ptr, host_irq, start_pulse and chan_active are all zero.
- R2: A command write stores only bit 0 (run) and bit 3 (direction). cmd_rdata reads {4'b0, dir, 2'b0, run}, and xfer_dir follows the stored direction bit.
- R3: A command write whose bit 0 equals the stored run bit updates the direction only. It produces no start pulse, no change of the active flag and no pointer reload.
- R4: A run-bit change from 0 to 1 while the channel is inactive sets chan_active and loads work_ptr from tbl_base. It also raises start_pulse for exactly one cycle, all visible in the cycle after the write.
- R5: A run-bit change from 0 to 1 while chan_active is already set reloads work_ptr from tbl_base but produces no start pulse. The decision uses the active flag as held before the write cycle, and the command event overrides a same-cycle walker update.
- R6: A run-bit change from 1 to 0 clears chan_active in the next cycle.
- R7: A pointer write of 2^size bytes (size code 0, 1 or 2; code 3 means the full width) at byte offset ptr_wr_offset replaces only the addressed byte lanes, filling them from the low bytes of ptr_wdata. Lanes beyond the top are dropped, and tbl_base bits 1:0 are always zero.
- R8: ptr_rdata equals tbl_base shifted right by 8*ptr_rd_offset, with every byte at or above 2^ptr_rd_size (capped at the full width) forced to zero. The output is combinational.
- R9: host_irq follows dev_irq one cycle later. A rising edge of dev_irq sets status bit 2 in the same cycle that host_irq rises. A falling edge lowers host_irq and leaves bit 2 unchanged.
- R10: A status write clears bit 1 (error) and bit 2 (interrupt) where the written bit is 1. Bit 0 (active) cannot be written. A same-cycle set of a flag wins over its clear.
- R11: walker_done loads chan_active with walker_more.
- R12: walk_step advances work_ptr by DESC_BYTES. A same-cycle reload from tbl_base takes precedence.
- R13: walker_err sets status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command write data |
| cmd_rdata | output | 8 | Command register read value |
| sts_wr_en | input | 1 | Status register write strobe |
| sts_wdata | input | 8 | Status write data (write 1 to clear) |
| sts_rdata | output | 8 | Status read value: bit0 active, bit1 error, bit2 interrupt |
| ptr_wr_en | input | 1 | Table pointer write strobe |
| ptr_wr_offset | input | OFF_W | Byte offset of the pointer write |
| ptr_wr_size | input | 2 | log2 of the pointer write width in bytes |
| ptr_wdata | input | PTR_W | Pointer write data, low-aligned |
| ptr_rd_offset | input | OFF_W | Byte offset of the pointer read |
| ptr_rd_size | input | 2 | log2 of the pointer read width in bytes |
| ptr_rdata | output | PTR_W | Pointer read data, low-aligned |
| dev_irq | input | 1 | Interrupt level from the storage device |
| host_irq | output | 1 | Interrupt level to the host |
| walker_done | input | 1 | Walker finished a transfer phase |
| walker_more | input | 1 | With walker_done: more data is expected |
| walker_err | input | 1 | Walker detected an error |
| walk_step | input | 1 | Walker consumed one descriptor |
| tbl_base | output | PTR_W | Descriptor table base address |
| work_ptr | output | PTR_W | Working descriptor pointer |
| start_pulse | output | 1 | One-cycle start request to the walker |
| xfer_dir | output | 1 | Stored direction bit |
| chan_active | output | 1 | Channel active flag |

## Verification
The bench uses the default PTR_W of 32 and DESC_BYTES of 8. This gives four byte lanes, so every offset and size pairing can be reached, including writes and reads that run past the top lane and are truncated. With four lanes the low two forced-zero bits share the bottom lane with the byte writes, so a byte write at offset 0 exposes the masking. The 8-byte stride makes repeated walker steps and their collision with a reload easy to predict.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    // status register bit positions
    localparam int STS_ACT_BIT = 0;
    localparam int STS_ERR_BIT = 1;
    localparam int STS_IRQ_BIT = 2;
    // command register bit positions
    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 3;
    // width of the access-size code
    localparam int SIZE_W = 2;

    // number of bytes covered by an access-size code, capped at lanes
    function automatic int lane_count(input logic [SIZE_W-1:0] sz, input int lanes);
        int n;
        n = 1 << sz;
        if (n > lanes) n = lanes;
        return n;
    endfunction
endpackage

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg
    import bmdma_pkg::*;
#(
    parameter int PTR_W = 32,
    localparam int LANES = PTR_W / 8,
    localparam int OFF_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_offset,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [PTR_W-1:0]  wdata,
    input  logic [OFF_W-1:0]  rd_offset,
    input  logic [SIZE_W-1:0] rd_size,
    output logic [PTR_W-1:0]  base,
    output logic [PTR_W-1:0]  rdata
);
    typedef struct packed {
        logic [PTR_W-1:0] base;
    } ptr_state_t;

    ptr_state_t       state_q, state_d;
    logic [LANES-1:0] wr_lane_hit;
    logic [LANES-1:0] rd_lane_keep;
    logic [PTR_W-1:0] wr_shifted;
    logic [PTR_W-1:0] rd_shifted;
    int               wr_bytes;
    int               rd_bytes;

    assign wr_bytes   = lane_count(wr_size, LANES);
    assign rd_bytes   = lane_count(rd_size, LANES);
    assign wr_shifted = wdata << (8 * int'(wr_offset));
    assign rd_shifted = state_q.base >> (8 * int'(rd_offset));

    // per-lane select for the write merge and the read mask
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wr_lane_hit[i]  = (i >= int'(wr_offset)) && (i < int'(wr_offset) + wr_bytes);
        assign rd_lane_keep[i] = (i < rd_bytes);
        assign rdata[8*i +: 8] = rd_lane_keep[i] ? rd_shifted[8*i +: 8] : 8'h00;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_lane_hit[i]) state_d.base[8*i +: 8] = wr_shifted[8*i +: 8];
            end
        end
        // dword alignment of the table is enforced here
        state_d.base[1:0] = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign base = state_q.base;
endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
    import bmdma_pkg::*;
#(
    parameter int PTR_W      = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_en,
    input  logic [7:0]       cmd_wdata,
    input  logic             sts_wr_en,
    input  logic [7:0]       sts_wdata,
    input  logic             dev_irq,
    input  logic             walker_done,
    input  logic             walker_more,
    input  logic             walker_err,
    input  logic             walk_step,
    input  logic [PTR_W-1:0] base,
    output logic [7:0]       cmd_rdata,
    output logic [7:0]       sts_rdata,
    output logic             host_irq,
    output logic             start_pulse,
    output logic             xfer_dir,
    output logic             chan_active,
    output logic [PTR_W-1:0] work_ptr
);
    localparam logic [PTR_W-1:0] STRIDE = PTR_W'(DESC_BYTES);

    typedef struct packed {
        logic             run;
        logic             dir;
        logic             active;
        logic             err;
        logic             irq;
        logic             host_irq;
        logic             pulse;
        logic [PTR_W-1:0] work;
    } ctrl_state_t;

    ctrl_state_t state_q, state_d;
    logic        new_run;
    logic        run_flip;
    logic        irq_rise;
    logic        unused_wbits;

    assign new_run      = cmd_wdata[CMD_RUN_BIT];
    assign run_flip     = cmd_wr_en && (new_run != state_q.run);
    assign irq_rise     = dev_irq && !state_q.host_irq;
    assign unused_wbits = ^{cmd_wdata[7:4], cmd_wdata[2:1], sts_wdata[7:3], sts_wdata[0]};

    always_comb begin
        state_d          = state_q;
        state_d.pulse    = 1'b0;
        state_d.host_irq = dev_irq;

        if (walk_step) state_d.work = state_q.work + STRIDE;

        // write-one-to-clear first, so a same-cycle set wins
        if (sts_wr_en) begin
            if (sts_wdata[STS_ERR_BIT]) state_d.err = 1'b0;
            if (sts_wdata[STS_IRQ_BIT]) state_d.irq = 1'b0;
        end
        if (walker_err) state_d.err = 1'b1;
        if (irq_rise)   state_d.irq = 1'b1;

        if (walker_done) state_d.active = walker_more;

        if (cmd_wr_en) begin
            state_d.run = new_run;
            state_d.dir = cmd_wdata[CMD_DIR_BIT];
        end
        if (run_flip) begin
            if (!new_run) begin
                state_d.active = 1'b0;
            end else begin
                state_d.work = base;
                if (!state_q.active) begin
                    state_d.active = 1'b1;
                    state_d.pulse  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        cmd_rdata              = 8'h00;
        cmd_rdata[CMD_RUN_BIT] = state_q.run;
        cmd_rdata[CMD_DIR_BIT] = state_q.dir;
        sts_rdata              = 8'h00;
        sts_rdata[STS_ACT_BIT] = state_q.active;
        sts_rdata[STS_ERR_BIT] = state_q.err;
        sts_rdata[STS_IRQ_BIT] = state_q.irq;
    end

    assign host_irq    = state_q.host_irq;
    assign start_pulse = state_q.pulse;
    assign xfer_dir    = state_q.dir;
    assign chan_active = state_q.active;
    assign work_ptr    = state_q.work;
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
#(
    parameter int PTR_W      = 32,
    parameter int DESC_BYTES = 8,
    localparam int OFF_W     = (PTR_W / 8 > 1) ? $clog2(PTR_W / 8) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_en,
    input  logic [7:0]        cmd_wdata,
    output logic [7:0]        cmd_rdata,
    input  logic              sts_wr_en,
    input  logic [7:0]        sts_wdata,
    output logic [7:0]        sts_rdata,
    input  logic              ptr_wr_en,
    input  logic [OFF_W-1:0]  ptr_wr_offset,
    input  logic [SIZE_W-1:0] ptr_wr_size,
    input  logic [PTR_W-1:0]  ptr_wdata,
    input  logic [OFF_W-1:0]  ptr_rd_offset,
    input  logic [SIZE_W-1:0] ptr_rd_size,
    output logic [PTR_W-1:0]  ptr_rdata,
    input  logic              dev_irq,
    output logic              host_irq,
    input  logic              walker_done,
    input  logic              walker_more,
    input  logic              walker_err,
    input  logic              walk_step,
    output logic [PTR_W-1:0]  tbl_base,
    output logic [PTR_W-1:0]  work_ptr,
    output logic              start_pulse,
    output logic              xfer_dir,
    output logic              chan_active
);
    bmdma_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ptr_wr_en),
        .wr_offset (ptr_wr_offset),
        .wr_size   (ptr_wr_size),
        .wdata     (ptr_wdata),
        .rd_offset (ptr_rd_offset),
        .rd_size   (ptr_rd_size),
        .base      (tbl_base),
        .rdata     (ptr_rdata)
    );

    bmdma_ctrl #(.PTR_W(PTR_W), .DESC_BYTES(DESC_BYTES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_en   (cmd_wr_en),
        .cmd_wdata   (cmd_wdata),
        .sts_wr_en   (sts_wr_en),
        .sts_wdata   (sts_wdata),
        .dev_irq     (dev_irq),
        .walker_done (walker_done),
        .walker_more (walker_more),
        .walker_err  (walker_err),
        .walk_step   (walk_step),
        .base        (tbl_base),
        .cmd_rdata   (cmd_rdata),
        .sts_rdata   (sts_rdata),
        .host_irq    (host_irq),
        .start_pulse (start_pulse),
        .xfer_dir    (xfer_dir),
        .chan_active (chan_active),
        .work_ptr    (work_ptr)
    );
endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk #(
    parameter int PTR_W      = 32,
    parameter int DESC_BYTES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr_en,
    input logic [7:0]       cmd_wdata,
    input logic [7:0]       cmd_rdata,
    input logic             sts_wr_en,
    input logic [7:0]       sts_rdata,
    input logic             dev_irq,
    input logic             host_irq,
    input logic             walker_done,
    input logic             walk_step,
    input logic [PTR_W-1:0] tbl_base,
    input logic [PTR_W-1:0] work_ptr,
    input logic             start_pulse,
    input logic             chan_active
);
    logic run_rise;
    assign run_rise = cmd_wr_en && cmd_wdata[0] && !cmd_rdata[0];

    // R3: unchanged run bit never produces a start request
    a_r3_same_run_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_en && (cmd_wdata[0] == cmd_rdata[0])) |=> !start_pulse);

    // R4: start request lasts one cycle and coincides with active
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    a_r4_pulse_with_active: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> chan_active);

    // R5: restart while active reloads without a start request
    a_r5_reload_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (run_rise && chan_active) |=> (!start_pulse && work_ptr == $past(tbl_base)));

    // R6: stopping drops the active flag
    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_en && !cmd_wdata[0] && cmd_rdata[0]) |=> !chan_active);

    // R7: table base stays dword aligned
    a_r7_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_base[1:0] == 2'b00);

    // R9: host interrupt tracks the device with one cycle of delay
    a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq |=> host_irq);
    a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_irq |=> !host_irq);
    a_r9_rise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> sts_rdata[2]);

    // R10: a status write cannot raise the active flag
    a_r10_active_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_en && !chan_active && !cmd_wr_en && !walker_done) |=> !chan_active);

    // R12: a step without reload advances by one descriptor
    a_r12_step: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_step && !run_rise) |=> (work_ptr == $past(work_ptr) + PTR_W'(DESC_BYTES)));
endmodule

bind bmdma_regfile bmdma_regfile_chk #(.PTR_W(PTR_W), .DESC_BYTES(DESC_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_en   (cmd_wr_en),
    .cmd_wdata   (cmd_wdata),
    .cmd_rdata   (cmd_rdata),
    .sts_wr_en   (sts_wr_en),
    .sts_rdata   (sts_rdata),
    .dev_irq     (dev_irq),
    .host_irq    (host_irq),
    .walker_done (walker_done),
    .walk_step   (walk_step),
    .tbl_base    (tbl_base),
    .work_ptr    (work_ptr),
    .start_pulse (start_pulse),
    .chan_active (chan_active)
);

// File: tb/bmdma_regfile_tb_top.sv
`timescale 1ns/1ps
module bmdma_regfile_tb_top;
    localparam int PTR_W = 32;
    localparam int DESC  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 0, sts_wr_en = 0, ptr_wr_en = 0;
    logic [7:0]  cmd_wdata = 0, sts_wdata = 0;
    logic [1:0]  ptr_wr_offset = 0, ptr_wr_size = 0, ptr_rd_offset = 0, ptr_rd_size = 0;
    logic [31:0] ptr_wdata = 0;
    logic        dev_irq = 0, walker_done = 0, walker_more = 0, walker_err = 0, walk_step = 0;
    logic [7:0]  cmd_rdata, sts_rdata;
    logic [31:0] ptr_rdata, tbl_base, work_ptr;
    logic        host_irq, start_pulse, xfer_dir, chan_active;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    logic        m_run = 0, m_dir = 0, m_act = 0, m_err = 0, m_irq = 0, m_hirq = 0, m_pulse = 0;
    logic [31:0] m_base = 0, m_work = 0;

    always #4 clk = ~clk;

    bmdma_regfile #(.PTR_W(PTR_W), .DESC_BYTES(DESC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr_en(cmd_wr_en), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .sts_wr_en(sts_wr_en), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_offset(ptr_wr_offset), .ptr_wr_size(ptr_wr_size),
        .ptr_wdata(ptr_wdata), .ptr_rd_offset(ptr_rd_offset), .ptr_rd_size(ptr_rd_size),
        .ptr_rdata(ptr_rdata), .dev_irq(dev_irq), .host_irq(host_irq),
        .walker_done(walker_done), .walker_more(walker_more), .walker_err(walker_err),
        .walk_step(walk_step), .tbl_base(tbl_base), .work_ptr(work_ptr),
        .start_pulse(start_pulse), .xfer_dir(xfer_dir), .chan_active(chan_active)
    );

    function automatic int nbytes(input int sz);
        return (sz >= 2) ? 4 : (1 << sz);
    endfunction

    function automatic logic [31:0] exp_ptr_wr(input logic [31:0] old, input int off,
                                                input int sz, input logic [31:0] data);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++)
            if (i >= off && i < off + nbytes(sz)) r[8*i +: 8] = data[8*(i-off) +: 8];
        r[1:0] = 2'b00;
        return r;
    endfunction

    function automatic logic [31:0] exp_ptr_rd(input logic [31:0] b, input int off, input int sz);
        logic [31:0] r = b >> (8 * off);
        for (int i = 0; i < 4; i++)
            if (i >= nbytes(sz)) r[8*i +: 8] = 8'h00;
        return r;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 R3 cmd_rdata", {24'h0, cmd_rdata}, {28'h0, m_dir, 2'b00, m_run});
        chk("R2 xfer_dir", {31'h0, xfer_dir}, {31'h0, m_dir});
        chk("R4 R5 R6 R9 R10 R11 R13 sts_rdata", {24'h0, sts_rdata}, {29'h0, m_irq, m_err, m_act});
        chk("R3 R4 R5 start_pulse", {31'h0, start_pulse}, {31'h0, m_pulse});
        chk("R6 R11 chan_active", {31'h0, chan_active}, {31'h0, m_act});
        chk("R9 host_irq", {31'h0, host_irq}, {31'h0, m_hirq});
        chk("R7 tbl_base", tbl_base, m_base);
        chk("R5 R12 work_ptr", work_ptr, m_work);
        chk("R8 ptr_rdata", ptr_rdata, exp_ptr_rd(m_base, int'(ptr_rd_offset), int'(ptr_rd_size)));
    endtask

    task automatic clear_inputs();
        cmd_wr_en = 0; sts_wr_en = 0; ptr_wr_en = 0;
        walker_done = 0; walker_more = 0; walker_err = 0; walk_step = 0;
    endtask

    // advance one clock with the inputs currently driven and check all outputs
    task automatic step();
        logic n_run = m_run, n_dir = m_dir, n_act = m_act, n_err = m_err, n_irq = m_irq;
        logic [31:0] n_work = m_work, n_base = m_base;
        logic n_pulse = 0;
        if (walk_step) n_work = m_work + DESC;
        if (sts_wr_en && sts_wdata[1]) n_err = 0;
        if (sts_wr_en && sts_wdata[2]) n_irq = 0;
        if (walker_err) n_err = 1;
        if (dev_irq && !m_hirq) n_irq = 1;
        if (walker_done) n_act = walker_more;
        if (cmd_wr_en) begin
            n_run = cmd_wdata[0];
            n_dir = cmd_wdata[3];
            if (cmd_wdata[0] != m_run) begin
                if (!cmd_wdata[0]) n_act = 0;
                else begin
                    n_work = m_base;
                    if (!m_act) begin n_act = 1; n_pulse = 1; end
                end
            end
        end
        if (ptr_wr_en) n_base = exp_ptr_wr(m_base, int'(ptr_wr_offset), int'(ptr_wr_size), ptr_wdata);
        @(posedge clk);
        @(negedge clk);
        m_run = n_run; m_dir = n_dir; m_act = n_act; m_err = n_err; m_irq = n_irq;
        m_hirq = dev_irq; m_pulse = n_pulse; m_work = n_work; m_base = n_base;
        compare_all();
        clear_inputs();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cmd_rdata", {24'h0, cmd_rdata}, 32'h0);
        chk("R1 sts_rdata", {24'h0, sts_rdata}, 32'h0);
        chk("R1 tbl_base", tbl_base, 32'h0);
        chk("R1 work_ptr", work_ptr, 32'h0);
        chk("R1 outputs", {29'h0, host_irq, start_pulse, chan_active}, 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R7: full write, low bits masked
        ptr_wr_en = 1; ptr_wr_offset = 0; ptr_wr_size = 2; ptr_wdata = 32'hDEADBEEF;
        step();
        chk("R7 full write", tbl_base, 32'hDEADBEEC);
        // R8: two bytes from offset 1
        ptr_rd_offset = 1; ptr_rd_size = 1; #1;
        chk("R8 read off1 w2", ptr_rdata, 32'h0000ADBE);
        // R7: single byte lane at offset 2
        ptr_wr_en = 1; ptr_wr_offset = 2; ptr_wr_size = 0; ptr_wdata = 32'h00000055;
        step();
        chk("R7 byte lane", tbl_base, 32'hDE55BEEC);
        // R7: 4-byte write at offset 3 keeps only the top lane
        ptr_wr_en = 1; ptr_wr_offset = 3; ptr_wr_size = 2; ptr_wdata = 32'h44332211;
        step();
        chk("R7 truncated", tbl_base, 32'h1155BEEC);

        // R4: start from idle
        cmd_wr_en = 1; cmd_wdata = 8'h09;
        step();
        chk("R4 pulse", {31'h0, start_pulse}, 32'h1);
        chk("R4 reload", work_ptr, 32'h1155BEEC);
        // R2 R3: same run bit, extra bits dropped
        cmd_wr_en = 1; cmd_wdata = 8'hF7;
        step();
        chk("R3 no pulse", {31'h0, start_pulse}, 32'h0);
        chk("R2 masked cmd", {24'h0, cmd_rdata}, 32'h00000001);
        // R12: two steps
        walk_step = 1; step();
        walk_step = 1; step();
        chk("R12 stride", work_ptr, 32'h1155BEEC + 32'd16);
        // R6: stop
        cmd_wr_en = 1; cmd_wdata = 8'h00;
        step();
        chk("R6 stopped", {31'h0, chan_active}, 32'h0);

        // R9: interrupt rise and fall
        dev_irq = 1; step();
        chk("R9 flag set", {31'h0, sts_rdata[2]}, 32'h1);
        dev_irq = 0; step();
        chk("R9 flag kept", {31'h0, sts_rdata[2]}, 32'h1);
        chk("R9 host low", {31'h0, host_irq}, 32'h0);
        // R10: active not writable, W1C of irq
        sts_wr_en = 1; sts_wdata = 8'h01; step();
        chk("R10 active unwritable", {31'h0, chan_active}, 32'h0);
        sts_wr_en = 1; sts_wdata = 8'h04; step();
        chk("R10 irq cleared", {24'h0, sts_rdata}, 32'h0);
        // R13 then R10 clear
        walker_err = 1; step();
        chk("R13 err set", {31'h0, sts_rdata[1]}, 32'h1);
        sts_wr_en = 1; sts_wdata = 8'h02; walker_err = 1; step();
        chk("R10 set wins", {31'h0, sts_rdata[1]}, 32'h1);
        sts_wr_en = 1; sts_wdata = 8'h02; step();
        chk("R10 err cleared", {31'h0, sts_rdata[1]}, 32'h0);

        // R11 then R5: active via walker, restart without pulse
        walker_done = 1; walker_more = 1; step();
        chk("R11 more", {31'h0, chan_active}, 32'h1);
        walk_step = 1; step();
        cmd_wr_en = 1; cmd_wdata = 8'h01; walk_step = 1; step();
        chk("R5 no pulse", {31'h0, start_pulse}, 32'h0);
        chk("R5 R12 reload wins", work_ptr, tbl_base);
        walker_done = 1; walker_more = 0; step();
        chk("R11 done", {31'h0, chan_active}, 32'h0);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            cmd_wr_en     = ($urandom_range(0, 5) == 0);
            cmd_wdata     = 8'($urandom());
            sts_wr_en     = ($urandom_range(0, 7) == 0);
            sts_wdata     = 8'($urandom());
            ptr_wr_en     = ($urandom_range(0, 4) == 0);
            ptr_wr_offset = 2'($urandom());
            ptr_wr_size   = 2'($urandom());
            ptr_wdata     = $urandom();
            ptr_rd_offset = 2'($urandom());
            ptr_rd_size   = 2'($urandom());
            if ($urandom_range(0, 9) == 0) dev_irq = ~dev_irq;
            walker_done   = ($urandom_range(0, 11) == 0);
            walker_more   = 1'($urandom());
            walker_err    = ($urandom_range(0, 19) == 0);
            walk_step     = ($urandom_range(0, 3) == 0);
            step();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule